// File: doc/BRIEF.md
# Masked-Write Coprocessor Control Register

This block is the 16-bit control word of a small coprocessor, written and read over a plain synchronous register bus. The low byte carries six control bits. Each of them has a partner in the high byte: a write alters a control bit only when its partner is written as 1 in the same access. Software can therefore change one bit without reading the word first. The partner (mask) bits are never stored.

Beyond holding the bits, the register gates incoming service requests and decides whether the core may run. Debug mode can be entered from two breakpoint inputs as well as by software. A software-error flag is set by internal logic and can only be cleared by software.

Top module: `cpctl_reg`

## Requirements
- R1: Control bits sit at rdata[0] request enable, [1] freeze halt, [2] debug mode, [3] fake interrupt, [4] software error, [5] interrupt enable. The mask for bit i is wdata[8+i]. On a write, a control bit changes only when its mask is 1. A bit whose mask is 0 keeps its value.
- R2: rdata[15:6] always reads 0, so the mask bits read back as 0.
- R3: A masked write of 1 never sets the software error flag. A masked write of 0 clears it. A pulse on sw_err_evt sets it, and the pulse wins over a clearing write in the same cycle.
- R4: The fake-interrupt and interrupt-enable bits can each be set and cleared by masked writes.
- R5: req_accept is 1 exactly when request enable is 1, req_pending is 1 and core_busy is 0. With request enable at 0, pending requests are never accepted.
- R6: With freeze halt at 1 and freeze_in at 1, core_run is 0. With freeze halt at 0, freeze_in does not stop the core.
- R7: Debug mode is entered by a pulse on brk_sw, by a pulse on brk_tag, or by a masked write of 1. A masked write of 0 leaves debug mode.
- R8: A breakpoint pulse in the same cycle as a masked write of 0 to debug mode leaves debug mode at 1.
- R9: freeze_in and sw_err_evt do not change debug mode.
- R10: After reset all control bits are 0. A write or event at a clock edge shows on the outputs from that edge onward, one register stage.
- R11: core_run is 0 whenever debug mode is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 16 | Write word: masks in the high byte, values in the low byte |
| rdata | output | 16 | Read word |
| brk_sw | input | 1 | Software breakpoint hit |
| brk_tag | input | 1 | Tagged or forced breakpoint hit |
| sw_err_evt | input | 1 | Internal software-error event |
| freeze_in | input | 1 | Debug monitor active |
| req_pending | input | 1 | A service request is waiting |
| core_busy | input | 1 | A thread is executing |
| req_en | output | 1 | Request enable bit |
| frz_halt | output | 1 | Freeze halt bit |
| dbg_mode | output | 1 | Debug mode bit |
| fake_irq | output | 1 | Fake interrupt bit |
| sw_err | output | 1 | Software error flag |
| irq_en | output | 1 | Interrupt enable bit |
| core_run | output | 1 | Core may execute |
| req_accept | output | 1 | Request accepted this cycle |

## Verification
The assertions assume that the strobe and event inputs are clean, sampled levels at each rising edge. They also assume that a stable-bit check applies only when no hardware event targets that bit in the same cycle. The bench changes every input 1 ns after a rising edge and returns strobes and pulses to 0 after one cycle. Breakpoint and error events are raised only in the scenarios that test them, so the mask-hold properties see clean cycles elsewhere.

// File: rtl/cpctl_pkg.sv
package cpctl_pkg;
  localparam int DATA_W   = 16;
  localparam int NCTRL    = 6;
  localparam int MASK_OFS = DATA_W / 2;

  localparam int B_REQ = 0;
  localparam int B_FRZ = 1;
  localparam int B_DBG = 2;
  localparam int B_FAK = 3;
  localparam int B_SWE = 4;
  localparam int B_IEN = 5;

  // bits that software may drive to 1 (error flag is clear-only)
  localparam logic [NCTRL-1:0] SW_SET_OK = 6'b101111;

  function automatic logic mask_hit(input logic wr, input logic [DATA_W-1:0] w, input int idx);
    return wr & w[MASK_OFS + idx];
  endfunction

  function automatic logic [DATA_W-1:0] pack_read(input logic [NCTRL-1:0] c);
    return {{(DATA_W-NCTRL){1'b0}}, c};
  endfunction
endpackage

// File: rtl/cpctl_bit.sv
module cpctl_bit #(
  parameter bit ALLOW_SW_SET = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic val,
  input  logic hw_set,
  output logic q
);
  logic sw_take;
  assign sw_take = hit & (ALLOW_SW_SET | ~val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= 1'b0;
    else if (hw_set)  q <= 1'b1;
    else if (sw_take) q <= val;
  end
endmodule

// File: rtl/cpctl_gate.sv
module cpctl_gate (
  input  logic dbg,
  input  logic frz_bit,
  input  logic freeze_in,
  input  logic ren,
  input  logic pending,
  input  logic busy,
  output logic run,
  output logic accept
);
  logic frz_stop;
  assign frz_stop = frz_bit & freeze_in;
  assign run      = ~(dbg | frz_stop);
  assign accept   = ren & pending & ~busy;
endmodule

// File: rtl/cpctl_reg.sv
module cpctl_reg
  import cpctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              brk_sw,
  input  logic              brk_tag,
  input  logic              sw_err_evt,
  input  logic              freeze_in,
  input  logic              req_pending,
  input  logic              core_busy,
  output logic              req_en,
  output logic              frz_halt,
  output logic              dbg_mode,
  output logic              fake_irq,
  output logic              sw_err,
  output logic              irq_en,
  output logic              core_run,
  output logic              req_accept
);
  logic [NCTRL-1:0] ctrl_q;
  logic [NCTRL-1:0] ctrl_hit;
  logic [NCTRL-1:0] ctrl_hw;
  logic             brk_any;

  assign brk_any = brk_sw | brk_tag;

  always_comb begin
    ctrl_hw        = '0;
    ctrl_hw[B_DBG] = brk_any;
    ctrl_hw[B_SWE] = sw_err_evt;
  end

  for (genvar i = 0; i < NCTRL; i++) begin : g_bit
    assign ctrl_hit[i] = mask_hit(wr_en, wdata, i);
    cpctl_bit #(.ALLOW_SW_SET(SW_SET_OK[i])) u_bit (
      .clk    (clk),
      .rst_n  (rst_n),
      .hit    (ctrl_hit[i]),
      .val    (wdata[i]),
      .hw_set (ctrl_hw[i]),
      .q      (ctrl_q[i])
    );
  end

  assign rdata    = pack_read(ctrl_q);
  assign req_en   = ctrl_q[B_REQ];
  assign frz_halt = ctrl_q[B_FRZ];
  assign dbg_mode = ctrl_q[B_DBG];
  assign fake_irq = ctrl_q[B_FAK];
  assign sw_err   = ctrl_q[B_SWE];
  assign irq_en   = ctrl_q[B_IEN];

  cpctl_gate u_gate (
    .dbg       (dbg_mode),
    .frz_bit   (frz_halt),
    .freeze_in (freeze_in),
    .ren       (req_en),
    .pending   (req_pending),
    .busy      (core_busy),
    .run       (core_run),
    .accept    (req_accept)
  );
endmodule

// File: rtl/cpctl_chk.sv
module cpctl_chk
  import cpctl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              brk_sw,
  input logic              brk_tag,
  input logic              sw_err_evt,
  input logic              freeze_in,
  input logic              req_pending,
  input logic              core_busy,
  input logic              req_en,
  input logic              frz_halt,
  input logic              dbg_mode,
  input logic              sw_err,
  input logic              core_run,
  input logic              req_accept,
  input logic [NCTRL-1:0]  ctrl_hit
);
  AST_MASK_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_hit[B_REQ] |=> $stable(req_en)); // R1
  AST_READ_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DATA_W-1:NCTRL] == '0); // R2
  AST_SWERR_NO_SWSET: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_err && !sw_err_evt) |=> !sw_err); // R3
  AST_SWERR_EVT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    sw_err_evt |=> sw_err); // R3
  AST_ACCEPT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |-> (req_en && req_pending && !core_busy)); // R5
  AST_FRZ_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_halt && freeze_in) |-> !core_run); // R6
  AST_BRK_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_sw || brk_tag) |=> dbg_mode); // R8
  AST_DBG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_hit[B_DBG] && !brk_sw && !brk_tag) |=> $stable(dbg_mode)); // R9
  AST_DBG_NORUN: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_mode |-> !core_run); // R11
endmodule

bind cpctl_reg cpctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
  .brk_sw(brk_sw), .brk_tag(brk_tag), .sw_err_evt(sw_err_evt),
  .freeze_in(freeze_in), .req_pending(req_pending), .core_busy(core_busy),
  .req_en(req_en), .frz_halt(frz_halt), .dbg_mode(dbg_mode), .sw_err(sw_err),
  .core_run(core_run), .req_accept(req_accept), .ctrl_hit(ctrl_hit)
);

// File: tb/tb_cpctl_reg.sv
module tb_cpctl_reg;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [15:0] wdata = '0, rdata;
  logic brk_sw = 0, brk_tag = 0, sw_err_evt = 0, freeze_in = 0;
  logic req_pending = 0, core_busy = 0;
  logic req_en, frz_halt, dbg_mode, fake_irq, sw_err, irq_en, core_run, req_accept;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpctl_reg dut (.*);

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] mask, input logic [7:0] val);
    wr_en = 1; wdata = {mask, val};
    step();
    wr_en = 0; wdata = '0;
  endtask

  task automatic t_reset();
    chk("R10 reset rdata", rdata, 16'h0000);
    chk("R10 reset core_run", core_run, 1);
  endtask

  task automatic t_mask();
    wr(8'h00, 8'h3F);
    chk("R1 no mask no change", rdata, 16'h0000);
    wr(8'h21, 8'h3F);
    chk("R1 only masked bits set", rdata, 16'h0021);
    wr(8'h01, 8'h00);
    chk("R1 masked clear", rdata, 16'h0020);
    wr(8'hFF, 8'hC0);
    chk("R2 high bits read zero", rdata, 16'h0000);
  endtask

  task automatic t_fake_ien();
    wr(8'h28, 8'h28);
    chk("R4 set fake+ien", {fake_irq, irq_en}, 2'b11);
    wr(8'h08, 8'h00);
    chk("R4 clear fake only", {fake_irq, irq_en}, 2'b01);
    wr(8'h20, 8'h00);
    chk("R4 clear ien", irq_en, 0);
  endtask

  task automatic t_swerr();
    wr(8'h10, 8'h10);
    chk("R3 sw cannot set", sw_err, 0);
    sw_err_evt = 1; step(); sw_err_evt = 0;
    chk("R3 event sets", sw_err, 1);
    chk("R9 evt leaves dbg", dbg_mode, 0);
    sw_err_evt = 1; wr(8'h10, 8'h00); sw_err_evt = 0;
    chk("R3 event beats clear", sw_err, 1);
    wr(8'h10, 8'h00);
    chk("R3 masked clear", sw_err, 0);
  endtask

  task automatic t_accept();
    req_pending = 1; #1;
    chk("R5 disabled ignores", req_accept, 0);
    wr(8'h01, 8'h01);
    chk("R5 accept idle", req_accept, 1);
    core_busy = 1; #1;
    chk("R5 busy blocks", req_accept, 0);
    core_busy = 0; req_pending = 0; #1;
    chk("R5 no pending", req_accept, 0);
    wr(8'h01, 8'h00);
  endtask

  task automatic t_freeze();
    freeze_in = 1; #1;
    chk("R6 runs without halt bit", core_run, 1);
    chk("R9 freeze leaves dbg", dbg_mode, 0);
    wr(8'h02, 8'h02);
    chk("R6 halted in freeze", core_run, 0);
    freeze_in = 0; #1;
    chk("R6 resumes", core_run, 1);
    wr(8'h02, 8'h00);
  endtask

  task automatic t_debug();
    brk_sw = 1; step(); brk_sw = 0;
    chk("R7 brk_sw enters", dbg_mode, 1);
    chk("R11 dbg stops core", core_run, 0);
    wr(8'h04, 8'h00);
    chk("R7 masked 0 leaves", dbg_mode, 0);
    brk_tag = 1; step(); brk_tag = 0;
    chk("R7 brk_tag enters", dbg_mode, 1);
    wr(8'h00, 8'h00);
    chk("R1 unmasked keeps dbg", dbg_mode, 1);
    wr(8'h04, 8'h00);
    wr(8'h04, 8'h04);
    chk("R7 masked 1 enters", dbg_mode, 1);
    brk_sw = 1; wr(8'h04, 8'h00); brk_sw = 0;
    chk("R8 brk beats clear", dbg_mode, 1);
    wr(8'h04, 8'h00);
    chk("R11 run after leave", core_run, 1);
  endtask

  initial begin
    #1; t_reset();
    step(); step(); rst_n = 1; step();
    t_reset();
    t_mask();
    t_fake_ien();
    t_swerr();
    t_accept();
    t_freeze();
    t_debug();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule